// File: doc/BRIEF.md
# Break-Triggered Serial Wake Detector

This block sits beside the receive pin of an asynchronous serial port while the port sleeps. Software first arms it with a one-cycle strobe. While the chip is asleep and the block is armed, it watches the conditioned line for one falling edge followed by one rising edge. A break (the line held low for longer than a whole character) gives exactly this pattern. When the block sees it, it raises the receive interrupt, emits a one-cycle wake pulse and disarms itself.

Once disarmed, the line belongs to a plain 8N1 receiver with a fixed bit period. That receiver takes in the next character and raises the interrupt a second time. Software may also request rate detection before sleeping. In that case a ready indication is raised at the wake event, and the first character after the break is absorbed and not delivered, because it is the one a rate detector would measure.

Top module: `uart_brk_wake`

## Requirements
- R1: While reset is asserted, irq_o, wake_en_o, wake_pulse_o, rx_valid_o and abd_ready_o are all 0.
- R2: A one-cycle high on arm_i sets wake_en_o, which then stays 1 until a wake event clears it.
- R3: While wake_en_o is 1 and sleep_i is 1, a falling edge followed by a rising edge on the synchronized line produces wake_pulse_o high for exactly one cycle. In that same cycle irq_o becomes 1 and wake_en_o becomes 0.
- R4: Edges that occur while sleep_i is 0 do not advance the wake sequence. If sleep_i drops between the fall and the rise, the sequence restarts and waits for a new falling edge.
- R5: While wake_en_o is 0, a frame of one low start bit, 8 data bits sent least significant bit first and one high stop bit, each lasting CLKS_PER_BIT clocks, gives one cycle of rx_valid_o with the byte on rx_data_o. The following cycle irq_o is 1.
- R6: A frame whose stop bit is sampled low produces no rx_valid_o and does not set irq_o.
- R7: A low pulse shorter than half a bit period is rejected as a false start bit and produces no rx_valid_o.
- R8: irq_o stays 1 until a cycle with irq_clr_i high. If a new interrupt source and irq_clr_i arrive in the same cycle, irq_o is set.
- R9: If autobaud_en_i is 1 at the wake event, abd_ready_o rises with wake_pulse_o and falls once the first following frame ends. That frame produces neither rx_valid_o nor an interrupt.
- R10: While wake_en_o is 1, the receiver ignores the line and rx_valid_o stays 0.
- R11: Once a wake event has occurred, further breaks produce no further wake_pulse_o until arm_i is pulsed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Raw receive line, idle high |
| sleep_i | input | 1 | High while the chip is in its low-power state |
| arm_i | input | 1 | One-cycle strobe that sets the wake enable |
| autobaud_en_i | input | 1 | Request rate detection after wake |
| irq_clr_i | input | 1 | Write-one-to-clear strobe for irq_o |
| wake_en_o | output | 1 | Current wake-enable state |
| irq_o | output | 1 | Sticky receive interrupt flag |
| wake_pulse_o | output | 1 | One-cycle pulse on a wake event |
| rx_data_o | output | DATA_BITS | Last received character |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |
| abd_ready_o | output | 1 | Rate detection may proceed; first frame is being skipped |

## Verification
On every cycle, the embedded properties check several facts. The wake pulse is a single cycle and always comes with a set interrupt and a cleared enable. The interrupt only rises from a wake or an accepted byte, and it holds until cleared. Nothing is delivered while armed. A dropped sleep level sends the sequence back to waiting for a fall. The reference model in the bench covers what only whole scenarios can show: the exact bytes decoded from timed frames, the rejection of bad stop bits and short glitches, the skipped first frame in rate-detect mode, and the absence of any second wake after later breaks.

// File: rtl/uwk_pkg.sv
`timescale 1ns/1ps
package uwk_pkg;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_DATA  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_t;

   typedef enum logic {
      WK_SEEK_FALL = 1'b0,
      WK_SEEK_RISE = 1'b1
   } wk_state_t;

endpackage

// File: rtl/uwk_line.sv
`timescale 1ns/1ps
// Receive line conditioning: metastability chain plus edge detection.
module uwk_line #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_i,
   output logic line_o,
   output logic fall_o,
   output logic rise_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("uwk_line: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      genvar gi;
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= 1'b1;
               else        chain_q[gi] <= rx_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= 1'b1;
               else        chain_q[gi] <= chain_q[gi-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign line_o = chain_q[STAGES-1];
   assign fall_o = prev_q & ~line_o;
   assign rise_o = ~prev_q & line_o;

   assert_edges_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !fall_o);

endmodule

// File: rtl/uwk_wake.sv
`timescale 1ns/1ps
// Two-transition wake sequencer with self-clearing enable.
module uwk_wake
   import uwk_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic sleep_i,
   input  logic fall_i,
   input  logic rise_i,
   output logic en_o,
   output logic hit_o,
   output logic pulse_o
);

   wk_state_t st_q;
   logic      en_q;
   logic      active;

   assign active = en_q & sleep_i;
   assign hit_o  = active & (st_q == WK_SEEK_RISE) & rise_i;
   assign en_o   = en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= WK_SEEK_FALL;
      end else if (!active) begin
         st_q <= WK_SEEK_FALL;
      end else begin
         case (st_q)
            WK_SEEK_FALL: if (fall_i) st_q <= WK_SEEK_RISE;
            WK_SEEK_RISE: if (rise_i) st_q <= WK_SEEK_FALL;
            default:      st_q <= WK_SEEK_FALL;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         pulse_o <= 1'b0;
      end else begin
         pulse_o <= hit_o;
         if (hit_o)      en_q <= 1'b0;
         else if (arm_i) en_q <= 1'b1;
      end
   end

   assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |=> !pulse_o);

   assert_restart_when_awake_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == WK_SEEK_RISE && !sleep_i) |=> (st_q == WK_SEEK_FALL));

   assert_disarm_after_wake_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_o && !arm_i) |=> !en_q);

endmodule

// File: rtl/uwk_rx.sv
`timescale 1ns/1ps
// Fixed-period start/data/stop receiver, LSB first, mid-bit sampling.
module uwk_rx
   import uwk_pkg::*;
#(
   parameter int CLKS_PER_BIT = 16,
   parameter int DATA_BITS    = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en_i,
   input  logic                 line_i,
   input  logic                 fall_i,
   output logic                 end_o,
   output logic                 ok_o,
   output logic [DATA_BITS-1:0] data_o
);

   localparam int CW   = $clog2(CLKS_PER_BIT);
   localparam int IW   = $clog2(DATA_BITS);
   localparam int HALF = CLKS_PER_BIT / 2;
   localparam logic [CW-1:0] FULL_LAST = CW'(CLKS_PER_BIT - 1);
   localparam logic [CW-1:0] HALF_LAST = CW'(HALF - 1);
   localparam logic [IW-1:0] IDX_LAST  = IW'(DATA_BITS - 1);

   generate
      if (CLKS_PER_BIT < 4) begin : g_bad_period
         $error("uwk_rx: CLKS_PER_BIT must be at least 4");
      end
      if (DATA_BITS < 2) begin : g_bad_width
         $error("uwk_rx: DATA_BITS must be at least 2");
      end
   endgenerate

   rx_state_t            st_q;
   logic [CW-1:0]        cnt_q;
   logic [IW-1:0]        idx_q;
   logic [DATA_BITS-1:0] shift_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= RX_IDLE;
         cnt_q   <= '0;
         idx_q   <= '0;
         shift_q <= '0;
         end_o   <= 1'b0;
         ok_o    <= 1'b0;
      end else begin
         end_o <= 1'b0;
         if (!en_i) begin
            st_q <= RX_IDLE;
         end else begin
            case (st_q)
               RX_IDLE: begin
                  if (fall_i) begin
                     st_q  <= RX_START;
                     cnt_q <= '0;
                  end
               end
               RX_START: begin
                  if (cnt_q == HALF_LAST) begin
                     if (!line_i) begin
                        st_q  <= RX_DATA;
                        cnt_q <= '0;
                        idx_q <= '0;
                     end else begin
                        st_q <= RX_IDLE;
                     end
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (cnt_q == FULL_LAST) begin
                     shift_q <= {line_i, shift_q[DATA_BITS-1:1]};
                     cnt_q   <= '0;
                     if (idx_q == IDX_LAST) st_q <= RX_STOP;
                     else                   idx_q <= idx_q + 1'b1;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (cnt_q == FULL_LAST) begin
                     st_q  <= RX_IDLE;
                     end_o <= 1'b1;
                     ok_o  <= line_i;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               default: st_q <= RX_IDLE;
            endcase
         end
      end
   end

   assign data_o = shift_q;

   assert_frame_ends_from_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      end_o |-> $past(st_q == RX_STOP));

   assert_false_start_rejected_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && st_q == RX_START && cnt_q == HALF_LAST && line_i) |=> (st_q == RX_IDLE && !end_o));

endmodule

// File: rtl/uart_brk_wake.sv
`timescale 1ns/1ps
// Top: line conditioner, wake sequencer, receiver, interrupt and skip logic.
module uart_brk_wake #(
   parameter int CLKS_PER_BIT = 16,
   parameter int DATA_BITS    = 8,
   parameter int SYNC_STAGES  = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rx_i,
   input  logic                 sleep_i,
   input  logic                 arm_i,
   input  logic                 autobaud_en_i,
   input  logic                 irq_clr_i,
   output logic                 wake_en_o,
   output logic                 irq_o,
   output logic                 wake_pulse_o,
   output logic [DATA_BITS-1:0] rx_data_o,
   output logic                 rx_valid_o,
   output logic                 abd_ready_o
);

   logic line, fall, rise;
   logic wake_hit;
   logic frame_end, frame_ok;
   logic skip_q, irq_q;
   logic irq_set;

   uwk_line #(.STAGES(SYNC_STAGES)) i_line (
      .clk    (clk),
      .rst_n  (rst_n),
      .rx_i   (rx_i),
      .line_o (line),
      .fall_o (fall),
      .rise_o (rise)
   );

   uwk_wake i_wake (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm_i   (arm_i),
      .sleep_i (sleep_i),
      .fall_i  (fall),
      .rise_i  (rise),
      .en_o    (wake_en_o),
      .hit_o   (wake_hit),
      .pulse_o (wake_pulse_o)
   );

   uwk_rx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_BITS(DATA_BITS)) i_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (!wake_en_o),
      .line_i (line),
      .fall_i (fall),
      .end_o  (frame_end),
      .ok_o   (frame_ok),
      .data_o (rx_data_o)
   );

   assign rx_valid_o = frame_end & frame_ok & ~skip_q;
   assign irq_set    = wake_hit | rx_valid_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q  <= 1'b0;
         skip_q <= 1'b0;
      end else begin
         if (irq_set)        irq_q <= 1'b1;
         else if (irq_clr_i) irq_q <= 1'b0;
         if (wake_hit)       skip_q <= autobaud_en_i;
         else if (frame_end) skip_q <= 1'b0;
      end
   end

   assign irq_o       = irq_q;
   assign abd_ready_o = skip_q;

   assert_wake_raises_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse_o |-> (irq_o && !wake_en_o));

   assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !irq_clr_i) |=> irq_o);

   assert_irq_has_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> (wake_pulse_o || $past(rx_valid_o)));

   assert_quiet_while_armed_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wake_en_o |=> !rx_valid_o);

   assert_abd_follows_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(abd_ready_o) |-> wake_pulse_o);

endmodule

// File: tb/test_uart_brk_wake.sv
`timescale 1ns/1ps
module test_uart_brk_wake;

   localparam int CPB = 16;
   localparam int DW  = 8;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n, rx, sleep, arm, abd, clr;
   logic wake_en_o, irq_o, wake_pulse_o, rx_valid_o, abd_ready_o;
   logic [DW-1:0] rx_data_o;

   uart_brk_wake #(.CLKS_PER_BIT(CPB), .DATA_BITS(DW), .SYNC_STAGES(2)) i_uart_brk_wake (
      .clk           (clk),
      .rst_n         (rst_n),
      .rx_i          (rx),
      .sleep_i       (sleep),
      .arm_i         (arm),
      .autobaud_en_i (abd),
      .irq_clr_i     (clr),
      .wake_en_o     (wake_en_o),
      .irq_o         (irq_o),
      .wake_pulse_o  (wake_pulse_o),
      .rx_data_o     (rx_data_o),
      .rx_valid_o    (rx_valid_o),
      .abd_ready_o   (abd_ready_o)
   );

   int vectors = 0;
   int miscompares = 0;
   bit done = 0;

   task automatic chk(string tag, int act, int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Behavioural reference model
   bit sq[$];
   bit m_prev, m_end, m_ok, m_en, m_ph, m_pulse, m_irq, m_skip;
   int m_rs, m_cnt, m_idx, m_sh;

   always @(posedge clk) begin
      if (!rst_n) begin
         sq = '{1'b1, 1'b1};
         m_prev = 1; m_end = 0; m_ok = 0; m_en = 0; m_ph = 0;
         m_pulse = 0; m_irq = 0; m_skip = 0;
         m_rs = 0; m_cnt = 0; m_idx = 0; m_sh = 0;
      end else begin
         bit ln, fl, rs, hit, acc, fin, rxon;
         ln   = sq[0];
         fl   = m_prev && !ln;
         rs   = !m_prev && ln;
         hit  = m_en && sleep && m_ph && rs;
         acc  = m_end && m_ok && !m_skip;
         fin  = m_end;
         rxon = !m_en;
         m_end = 0;
         if (!rxon) m_rs = 0;
         else if (m_rs == 0) begin
            if (fl) begin m_rs = 1; m_cnt = 0; end
         end else if (m_rs == 1) begin
            if (m_cnt == CPB/2 - 1) begin
               if (!ln) begin m_rs = 2; m_cnt = 0; m_idx = 0; end
               else m_rs = 0;
            end else m_cnt++;
         end else if (m_rs == 2) begin
            if (m_cnt == CPB - 1) begin
               m_sh = (m_sh >> 1) | (int'(ln) << (DW - 1));
               m_cnt = 0;
               if (m_idx == DW - 1) m_rs = 3; else m_idx++;
            end else m_cnt++;
         end else begin
            if (m_cnt == CPB - 1) begin m_rs = 0; m_end = 1; m_ok = ln; end
            else m_cnt++;
         end
         m_pulse = hit;
         if (m_en && sleep) begin
            if (!m_ph) begin if (fl) m_ph = 1; end
            else if (rs) m_ph = 0;
         end else m_ph = 0;
         if (hit) m_en = 0; else if (arm) m_en = 1;
         if (hit || acc) m_irq = 1; else if (clr) m_irq = 0;
         if (hit) m_skip = abd; else if (fin) m_skip = 0;
         m_prev = ln;
         void'(sq.pop_front());
         sq.push_back(rx);
      end
   end

   int pulses = 0, valids = 0, last_data = 0;
   bit irq_seen = 0;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2 wake_en_o", int'(wake_en_o), int'(m_en));
         chk("R3 wake_pulse_o", int'(wake_pulse_o), int'(m_pulse));
         chk("R8 irq_o", int'(irq_o), int'(m_irq));
         chk("R9 abd_ready_o", int'(abd_ready_o), int'(m_skip));
         chk("R5 rx_valid_o", int'(rx_valid_o), int'(m_end && m_ok && !m_skip));
         if (rx_valid_o) chk("R5 rx_data_o", int'(rx_data_o), m_sh);
         if (wake_pulse_o) pulses++;
         if (rx_valid_o) begin valids++; last_data = int'(rx_data_o); end
         if (irq_o) irq_seen = 1;
      end
   end

   task automatic hold(bit v, int n);
      rx = v;
      repeat (n) @(negedge clk);
   endtask

   task automatic send_frame(logic [7:0] b, bit stop_ok);
      hold(0, CPB);
      for (int i = 0; i < DW; i++) hold(b[i], CPB);
      hold(stop_ok, CPB);
      hold(1, 3 * CPB);
   endtask

   task automatic send_break();
      hold(0, 12 * CPB);
      hold(1, 2 * CPB);
   endtask

   task automatic pulse_arm();
      arm = 1; @(negedge clk); arm = 0;
   endtask

   task automatic pulse_clr();
      clr = 1; @(negedge clk); clr = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      rst_n = 0; rx = 1; sleep = 0; arm = 0; abd = 0; clr = 0;
      repeat (4) @(negedge clk);
      // R1: reset state
      chk("R1 irq_o", int'(irq_o), 0);
      chk("R1 wake_en_o", int'(wake_en_o), 0);
      chk("R1 wake_pulse_o", int'(wake_pulse_o), 0);
      chk("R1 rx_valid_o", int'(rx_valid_o), 0);
      chk("R1 abd_ready_o", int'(abd_ready_o), 0);
      rst_n = 1;
      hold(1, 10);

      // R5: normal reception while not armed
      send_frame(8'h3C, 1);
      chk("R5 valid count", valids, 1);
      chk("R5 data", last_data, 32'h3C);
      hold(1, 5);
      chk("R8 irq held", int'(irq_o), 1);
      pulse_clr();
      hold(1, 2);
      chk("R8 irq cleared", int'(irq_o), 0);

      // R2: arm sets enable
      pulse_arm();
      hold(1, 3);
      chk("R2 armed", int'(wake_en_o), 1);

      // R10: frame while armed is ignored; R4: awake edges do not wake
      send_frame(8'h55, 1);
      chk("R10 no delivery while armed", valids, 1);
      chk("R4 no wake while awake", pulses, 0);
      chk("R2 still armed", int'(wake_en_o), 1);

      // R4: sleep drops between fall and rise
      sleep = 1;
      hold(1, 4);
      hold(0, 40);
      sleep = 0;
      hold(0, 4);
      hold(1, 20);
      sleep = 1;
      hold(1, 10);
      chk("R4 interrupted sequence", pulses, 0);

      // R3: break wakes
      send_break();
      chk("R3 one wake pulse", pulses, 1);
      chk("R3 irq set", int'(irq_o), 1);
      chk("R3 enable cleared", int'(wake_en_o), 0);
      pulse_clr();

      // R5: next byte after wake
      send_frame(8'hA5, 1);
      chk("R5 byte after wake", last_data, 32'hA5);
      chk("R5 valid count after wake", valids, 2);
      chk("R5 second irq", int'(irq_o), 1);
      pulse_clr();

      // R11: later break does not wake again
      send_break();
      chk("R11 no second wake", pulses, 1);

      // R6: bad stop bit
      hold(1, 2 * CPB);
      pulse_clr();
      send_frame(8'h0F, 0);
      chk("R6 bad stop dropped", valids, 2);
      chk("R6 no irq", int'(irq_o), 0);

      // R7: short glitch
      hold(0, 3);
      hold(1, 3 * CPB);
      chk("R7 glitch rejected", valids, 2);
      chk("R7 no irq", int'(irq_o), 0);

      // R8: set wins over a clear held through the frame
      irq_seen = 0;
      clr = 1;
      send_frame(8'h81, 1);
      clr = 0;
      hold(1, 2);
      chk("R8 set beats clear", int'(irq_seen), 1);
      chk("R8 cleared afterwards", int'(irq_o), 0);
      chk("R5 data 81", last_data, 32'h81);

      // R9: rate-detect mode skips first frame
      abd = 1;
      pulse_arm();
      hold(1, 4);
      send_break();
      chk("R9 ready after wake", int'(abd_ready_o), 1);
      chk("R9 wake count", pulses, 2);
      pulse_clr();
      send_frame(8'h12, 1);
      chk("R9 first frame skipped", valids, 3);
      chk("R9 ready dropped", int'(abd_ready_o), 0);
      chk("R9 no irq for skipped", int'(irq_o), 0);
      send_frame(8'h34, 1);
      chk("R9 second frame delivered", last_data, 32'h34);
      chk("R9 valid count", valids, 4);
      abd = 0;
      hold(1, 10);

      finish_run();
   end

endmodule